// File: doc/BRIEF.md
# Core Fuse/Split Mode Controller

This controller changes a row of small out-of-order cores between running on their own and running as one wider core. A request names an aligned group of two or four cores and asks either to join them or to separate them again. For a join, the controller first has every member discard its speculative work and its instruction-cache contents. It then has the fetch, steering and instruction-cache logic of each member switch to the new group width. For a separation, it waits until every member has retired its in-flight work before it restores the single-core configuration. Each step raises one request line per member core and moves on only when every member has acknowledged.

The controller holds a per-core mode table and a per-core free flag. A request that cannot be honoured gets a one-cycle refusal and changes nothing; it is not treated as a fault. The allocator may claim free cores and release single cores through two mask inputs. Data caches are never touched, so the controller has no data-cache port.

Top module: `core_fuse_ctrl`

## Requirements
- R1: After reset every core is in single mode (mode code 0), every `free_mask` bit is 1, `busy` is 0, and no flush, drain or reconfiguration request is raised.
- R2: A join request (`req_split`=0) with `req_quad`=0 (two cores) or 1 (four cores) is legal when `req_base` is a multiple of the group length, the group fits in the core row, and every member is free and in single mode. On completion each member carries mode code 1 (pair) or 2 (quad), and its `free_mask` bit is 0.
- R3: A legal join raises `flush_req` only on the members, collects a flush acknowledge from each of them, and only then raises `recfg_req`. It never raises `drain_req`.
- R4: A legal split (`req_split`=1) raises `drain_req` only on the members and raises `recfg_req` only after every member has acknowledged the drain. It never raises `flush_req`.
- R5: A split is legal when the group is aligned and every member holds exactly the mode code of the named width. On completion the members are back in mode 0 and their `free_mask` bits are 1.
- R6: An illegal join (misaligned base, a member not free, or a member already joined) produces `refuse` high for exactly the cycle after the request. It raises no handshake and leaves `core_mode` and `free_mask` unchanged.
- R7: A split naming a group that does not match an existing joined group of that width is refused in the same way as R6, with no state change.
- R8: From the cycle after an accepted request until `done` has been shown, `busy` is 1. A request presented while `busy` is 1 is ignored and never produces `done` or `refuse`.
- R9: Each step advances only after all members have acknowledged. Acknowledges from non-member cores are ignored, and a member's request line drops once that member has acknowledged.
- R10: `claim_mask` clears `free_mask` bits on the next cycle. `release_mask` sets them only for cores in single mode, so a release of a joined core has no effect.
- R11: While `recfg_req` is raised, `recfg_width` carries the target mode code: the group code for a join and 0 for a split. `done` is high for one cycle, and in that cycle `core_mode` and `free_mask` already show the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode-change request present |
| req_split | input | 1 | 0 = join, 1 = split |
| req_base | input | IDXW | Lowest core index of the group |
| req_quad | input | 1 | 0 = two-core group, 1 = four-core group |
| busy | output | 1 | Transition in progress, requests ignored |
| done | output | 1 | One-cycle completion pulse |
| refuse | output | 1 | One-cycle refusal pulse |
| flush_req | output | NCORES | Per-core flush request (join) |
| flush_ack | input | NCORES | Per-core flush acknowledge |
| drain_req | output | NCORES | Per-core drain request (split) |
| drain_ack | input | NCORES | Per-core drain acknowledge |
| recfg_req | output | NCORES | Per-core front-end reconfiguration request |
| recfg_ack | input | NCORES | Per-core reconfiguration acknowledge |
| recfg_width | output | 2 | Target mode code during reconfiguration |
| core_mode | output | 2*NCORES | Mode code per core, two bits each |
| free_mask | output | NCORES | Core free for allocation |
| claim_mask | input | NCORES | Allocator takes these cores |
| release_mask | input | NCORES | Allocator returns these single cores |

## Verification
Joins are tried at both widths and at different positions. The acknowledge delay differs from core to core and stray acknowledges arrive on cores outside the group, so a controller that advances on the first acknowledge, or on any acknowledge, gives a different handshake record from one that waits for every member. Refused joins cover a misaligned base, a core held by the allocator and an overlap with a joined group. Refused splits cover a width mismatch, each a different reason the legality check must see. A request made during a running join checks the back-pressure. Claim and release pulses, including a release aimed at a joined core, check the free mask apart from the transitions.

// File: rtl/cfuse_pkg.sv
package cfuse_pkg;

    typedef enum logic [1:0] {
        MODE_SOLO = 2'd0,
        MODE_PAIR = 2'd1,
        MODE_QUAD = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLUSH = 3'd1,
        ST_DRAIN = 3'd2,
        ST_RECFG = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

    typedef struct packed {
        logic  split;
        mode_e code;
    } xact_t;

    function automatic int group_len(logic quad);
        return quad ? 4 : 2;
    endfunction

    function automatic mode_e size_code(logic quad);
        return quad ? MODE_QUAD : MODE_PAIR;
    endfunction

endpackage

// File: rtl/cfuse_legal.sv
module cfuse_legal
    import cfuse_pkg::*;
#(
    parameter int NCORES = 8,
    localparam int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                  split,
    input  logic [IDXW-1:0]       base,
    input  logic                  quad,
    input  logic [2*NCORES-1:0]   mode_vec,
    input  logic [NCORES-1:0]     free_vec,
    output logic                  legal,
    output logic [NCORES-1:0]     members
);

    always_comb begin
        int    b;
        int    len;
        logic  aligned;
        logic  in_range;
        logic  all_ok;
        mode_e want;
        b        = int'(base);
        len      = group_len(quad);
        aligned  = (b % len) == 0;
        in_range = (b + len) <= NCORES;
        want     = size_code(quad);
        members  = '0;
        all_ok   = 1'b1;
        for (int i = 0; i < NCORES; i++) begin
            if (in_range && i >= b && i < b + len) begin
                members[i] = 1'b1;
                if (split) begin
                    if (mode_vec[2*i +: 2] != want) all_ok = 1'b0;
                end else begin
                    if (!free_vec[i] || mode_vec[2*i +: 2] != MODE_SOLO) all_ok = 1'b0;
                end
            end
        end
        legal = aligned && in_range && all_ok;
    end

endmodule

// File: rtl/cfuse_gather.sv
module cfuse_gather #(
    parameter int NCORES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [NCORES-1:0] members,
    input  logic [NCORES-1:0] ack,
    output logic [NCORES-1:0] pending,
    output logic              all_in
);

    logic [NCORES-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear) seen_q <= '0;
        else              seen_q <= seen_q | (ack & members);
    end

    assign pending = members & ~seen_q;
    assign all_in  = (seen_q & members) == members;

endmodule

// File: rtl/cfuse_modetab.sv
module cfuse_modetab
    import cfuse_pkg::*;
#(
    parameter int NCORES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [NCORES-1:0]   commit_mask,
    input  xact_t               commit_x,
    input  logic [NCORES-1:0]   claim_mask,
    input  logic [NCORES-1:0]   release_mask,
    output logic [2*NCORES-1:0] mode_vec,
    output logic [NCORES-1:0]   free_vec
);

    logic [2*NCORES-1:0] mode_q, mode_n;
    logic [NCORES-1:0]   free_q, free_n, solo;

    for (genvar g = 0; g < NCORES; g++) begin : g_solo
        assign solo[g] = mode_q[2*g +: 2] == MODE_SOLO;
    end

    always_comb begin
        mode_n = mode_q;
        free_n = (free_q & ~claim_mask) | (release_mask & solo);
        if (commit) begin
            for (int i = 0; i < NCORES; i++) begin
                if (commit_mask[i]) begin
                    mode_n[2*i +: 2] = commit_x.code;
                    free_n[i]        = commit_x.split;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            free_q <= '1;
        end else begin
            mode_q <= mode_n;
            free_q <= free_n;
        end
    end

    assign mode_vec = mode_q;
    assign free_vec = free_q;

endmodule

// File: rtl/core_fuse_ctrl.sv
module core_fuse_ctrl
    import cfuse_pkg::*;
#(
    parameter int NCORES = 8,
    localparam int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_split,
    input  logic [IDXW-1:0]       req_base,
    input  logic                  req_quad,
    output logic                  busy,
    output logic                  done,
    output logic                  refuse,
    output logic [NCORES-1:0]     flush_req,
    input  logic [NCORES-1:0]     flush_ack,
    output logic [NCORES-1:0]     drain_req,
    input  logic [NCORES-1:0]     drain_ack,
    output logic [NCORES-1:0]     recfg_req,
    input  logic [NCORES-1:0]     recfg_ack,
    output logic [1:0]            recfg_width,
    output logic [2*NCORES-1:0]   core_mode,
    output logic [NCORES-1:0]     free_mask,
    input  logic [NCORES-1:0]     claim_mask,
    input  logic [NCORES-1:0]     release_mask
);

    state_e            state_q;
    xact_t             xact_q;
    logic [NCORES-1:0] members_q;
    logic              refuse_q;

    logic              legal;
    logic [NCORES-1:0] members;
    logic [NCORES-1:0] step_ack;
    logic [NCORES-1:0] pending;
    logic              all_in;
    logic              in_step;
    logic              accept;
    logic              commit;

    cfuse_legal #(.NCORES(NCORES)) u_legal (
        .split    (req_split),
        .base     (req_base),
        .quad     (req_quad),
        .mode_vec (core_mode),
        .free_vec (free_mask),
        .legal    (legal),
        .members  (members)
    );

    always_comb begin
        case (state_q)
            ST_FLUSH: step_ack = flush_ack;
            ST_DRAIN: step_ack = drain_ack;
            ST_RECFG: step_ack = recfg_ack;
            default:  step_ack = '0;
        endcase
    end

    assign in_step = (state_q == ST_FLUSH) || (state_q == ST_DRAIN) || (state_q == ST_RECFG);
    assign accept  = (state_q == ST_IDLE) && req_valid && legal;
    assign commit  = (state_q == ST_RECFG) && all_in;

    cfuse_gather #(.NCORES(NCORES)) u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept || (in_step && all_in)),
        .members (members_q),
        .ack     (step_ack),
        .pending (pending),
        .all_in  (all_in)
    );

    cfuse_modetab #(.NCORES(NCORES)) u_modetab (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .commit_mask  (members_q),
        .commit_x     (xact_q),
        .claim_mask   (claim_mask),
        .release_mask (release_mask),
        .mode_vec     (core_mode),
        .free_vec     (free_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            xact_q    <= '{split: 1'b0, code: MODE_SOLO};
            members_q <= '0;
            refuse_q  <= 1'b0;
        end else begin
            refuse_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (legal) begin
                            state_q      <= req_split ? ST_DRAIN : ST_FLUSH;
                            members_q    <= members;
                            xact_q.split <= req_split;
                            xact_q.code  <= req_split ? MODE_SOLO : size_code(req_quad);
                        end else begin
                            refuse_q <= 1'b1;
                        end
                    end
                end
                ST_FLUSH, ST_DRAIN: if (all_in) state_q <= ST_RECFG;
                ST_RECFG:           if (all_in) state_q <= ST_DONE;
                default:            state_q <= ST_IDLE;
            endcase
        end
    end

    assign flush_req   = (state_q == ST_FLUSH) ? pending : '0;
    assign drain_req   = (state_q == ST_DRAIN) ? pending : '0;
    assign recfg_req   = (state_q == ST_RECFG) ? pending : '0;
    assign recfg_width = (state_q == ST_RECFG) ? xact_q.code : MODE_SOLO;
    assign busy        = state_q != ST_IDLE;
    assign done        = state_q == ST_DONE;
    assign refuse      = refuse_q;

endmodule

// File: rtl/cfuse_checks.sv
module cfuse_checks #(
    parameter int NCORES = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                done,
    input logic                refuse,
    input logic [NCORES-1:0]   flush_req,
    input logic [NCORES-1:0]   drain_req,
    input logic [NCORES-1:0]   recfg_req,
    input logic [2*NCORES-1:0] core_mode,
    input logic [NCORES-1:0]   free_mask
);

    a_r3_no_flush_with_drain: assert property (@(posedge clk) disable iff (rst)
        !((|flush_req) && (|drain_req)));

    a_r3_flush_not_with_recfg: assert property (@(posedge clk) disable iff (rst)
        !((|flush_req) && (|recfg_req)));

    a_r4_drain_not_with_recfg: assert property (@(posedge clk) disable iff (rst)
        !((|drain_req) && (|recfg_req)));

    a_r6_refuse_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        refuse |-> $stable(core_mode));

    a_r6_refuse_when_idle: assert property (@(posedge clk) disable iff (rst)
        refuse |-> (!busy && !done));

    a_r8_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    for (genvar g = 0; g < NCORES; g++) begin : g_free
        a_r2_free_is_solo: assert property (@(posedge clk) disable iff (rst)
            free_mask[g] |-> (core_mode[2*g +: 2] == 2'd0));
    end

endmodule

bind core_fuse_ctrl cfuse_checks #(.NCORES(NCORES)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .refuse    (refuse),
    .flush_req (flush_req),
    .drain_req (drain_req),
    .recfg_req (recfg_req),
    .core_mode (core_mode),
    .free_mask (free_mask)
);

// File: tb/core_fuse_ctrl_test.sv
module core_fuse_ctrl_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_split = 1'b0;
    logic [2:0]   req_base = '0;
    logic         req_quad = 1'b0;
    logic         busy, done, refuse;
    logic [N-1:0] flush_req, drain_req, recfg_req;
    logic [N-1:0] flush_ack, drain_ack, recfg_ack;
    logic [1:0]   recfg_width;
    logic [2*N-1:0] core_mode;
    logic [N-1:0] free_mask;
    logic [N-1:0] claim_mask = '0;
    logic [N-1:0] release_mask = '0;
    logic [N-1:0] stray = '0;
    logic [N-1:0] fl_m = '0, dr_m = '0, rc_m = '0;

    int nchecks = 0;
    int nerrors = 0;

    always #4 clk = ~clk;

    core_fuse_ctrl #(.NCORES(N)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_split(req_split),
        .req_base(req_base), .req_quad(req_quad), .busy(busy), .done(done),
        .refuse(refuse), .flush_req(flush_req), .flush_ack(flush_ack),
        .drain_req(drain_req), .drain_ack(drain_ack), .recfg_req(recfg_req),
        .recfg_ack(recfg_ack), .recfg_width(recfg_width), .core_mode(core_mode),
        .free_mask(free_mask), .claim_mask(claim_mask), .release_mask(release_mask)
    );

    assign flush_ack = fl_m | stray;
    assign drain_ack = dr_m | stray;
    assign recfg_ack = rc_m | stray;

    // Core-side responders: each core answers after its own delay.
    int fc[N], dc[N], rcc[N];
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || !flush_req[i]) begin fc[i] = 0; fl_m[i] <= 1'b0; end
            else begin fc[i]++; if (fc[i] > (i * 2) % 5 + 1) fl_m[i] <= 1'b1; end
            if (rst || !drain_req[i]) begin dc[i] = 0; dr_m[i] <= 1'b0; end
            else begin dc[i]++; if (dc[i] > (i * 3) % 4 + 1) dr_m[i] <= 1'b1; end
            if (rst || !recfg_req[i]) begin rcc[i] = 0; rc_m[i] <= 1'b0; end
            else begin rcc[i]++; if (rcc[i] > (i + 1) % 3 + 1) rc_m[i] <= 1'b1; end
        end
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    typedef struct {
        bit         is_refuse;
        logic [N-1:0] fl, dr, rc;
        logic [1:0] width;
        logic [2*N-1:0] mode;
        logic [N-1:0] free;
        string      rq;
    } exp_t;

    exp_t q[$];

    logic [2*N-1:0] mmode = '0;
    logic [N-1:0]   mfree = '1;

    // Monitor state
    logic [N-1:0] fl_seen = '0, dr_seen = '0, rc_seen = '0, fl_ok = '0, dr_ok = '0;
    logic [N-1:0] fl_at_rc = '0, dr_at_rc = '0;
    logic [1:0]   w_at_rc = '0;
    bit           rc_started = 0;

    always @(negedge clk) begin
        if (!rst) begin
            fl_seen = fl_seen | flush_req;
            dr_seen = dr_seen | drain_req;
            rc_seen = rc_seen | recfg_req;
            fl_ok   = fl_ok | (flush_req & flush_ack);
            dr_ok   = dr_ok | (drain_req & drain_ack);
            if ((|recfg_req) && !rc_started) begin
                rc_started = 1;
                fl_at_rc = fl_ok;
                dr_at_rc = dr_ok;
                w_at_rc  = recfg_width;
            end
            if (done || refuse) begin
                if (q.size() == 0) begin
                    nchecks++; nerrors++;
                    $display("FAIL R8 unexpected outcome: actual done=%0d refuse=%0d expected none", done, refuse);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.rq, "refuse vs done", {31'd0, refuse}, {31'd0, e.is_refuse});
                    chk(e.rq, "flush lines seen (R3)", 32'(fl_seen), 32'(e.fl));
                    chk(e.rq, "drain lines seen (R4)", 32'(dr_seen), 32'(e.dr));
                    chk(e.rq, "recfg lines seen", 32'(rc_seen), 32'(e.rc));
                    chk(e.rq, "flush acks before recfg (R9)", 32'(fl_at_rc), 32'(e.fl));
                    chk(e.rq, "drain acks before recfg (R9)", 32'(dr_at_rc), 32'(e.dr));
                    chk(e.rq, "recfg width (R11)", 32'(w_at_rc), 32'(e.width));
                    chk(e.rq, "core mode", 32'(core_mode), 32'(e.mode));
                    chk(e.rq, "free mask", 32'(free_mask), 32'(e.free));
                end
                fl_seen = '0; dr_seen = '0; rc_seen = '0; fl_ok = '0; dr_ok = '0;
                fl_at_rc = '0; dr_at_rc = '0; w_at_rc = '0; rc_started = 0;
            end
        end
    end

    task automatic issue(bit split, int base, bit quad, string rq, bit intrude);
        exp_t e;
        int   len;
        bit   ok;
        logic [N-1:0] mem;
        logic [1:0] want;
        len  = quad ? 4 : 2;
        want = quad ? 2'd2 : 2'd1;
        mem  = '0;
        ok   = (base % len == 0) && (base + len <= N);
        for (int i = 0; i < N; i++) begin
            if (i >= base && i < base + len && base + len <= N) begin
                mem[i] = 1'b1;
                if (split) begin
                    if (mmode[2*i +: 2] != want) ok = 0;
                end else if (!mfree[i] || mmode[2*i +: 2] != 2'd0) ok = 0;
            end
        end
        e.rq = rq;
        e.is_refuse = !ok;
        e.fl = (ok && !split) ? mem : '0;
        e.dr = (ok && split) ? mem : '0;
        e.rc = ok ? mem : '0;
        e.width = (ok && !split) ? want : 2'd0;
        if (ok) begin
            for (int i = 0; i < N; i++) begin
                if (mem[i]) begin
                    mmode[2*i +: 2] = split ? 2'd0 : want;
                    mfree[i] = split;
                end
            end
        end
        e.mode = mmode;
        e.free = mfree;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_split = split; req_base = 3'(base); req_quad = quad;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            @(negedge clk);
            chk("R8", "busy during transition", {31'd0, busy}, 32'd1);
            req_valid = 1'b1; req_split = 1'b0; req_base = 3'd2; req_quad = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        begin
            int t = 0;
            while (q.size() != 0 && t < 300) begin @(negedge clk); t++; end
        end
        if (q.size() != 0) begin
            nchecks++; nerrors++;
            $display("FAIL %s no outcome: actual none expected %s", rq, e.is_refuse ? "refuse" : "done");
            q.delete();
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic alloc(logic [N-1:0] cm, logic [N-1:0] rm, string rq);
        for (int i = 0; i < N; i++) begin
            if (cm[i]) mfree[i] = 1'b0;
            if (rm[i] && mmode[2*i +: 2] == 2'd0) mfree[i] = 1'b1;
        end
        @(negedge clk);
        claim_mask = cm; release_mask = rm;
        @(negedge clk);
        claim_mask = '0; release_mask = '0;
        chk(rq, "free mask after claim/release", 32'(free_mask), 32'(mfree));
        chk(rq, "mode unchanged by claim/release", 32'(core_mode), 32'(mmode));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchecks++; nerrors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "mode after reset", 32'(core_mode), 32'd0);
        chk("R1", "free after reset", 32'(free_mask), 32'hff);
        chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R1", "handshakes after reset", 32'(flush_req | drain_req | recfg_req), 32'd0);

        // R2 R3 R9 R11: pair join at 0, stray ack from core 7
        stray = 8'h80;
        issue(0, 0, 0, "R2", 0);
        stray = '0;
        // R2 R8: quad join at 4 with a request while busy
        issue(0, 4, 1, "R8", 1);
        // R6: misaligned, overlapping joined groups
        issue(0, 1, 0, "R6", 0);
        issue(0, 4, 0, "R6", 0);
        issue(0, 0, 1, "R6", 0);
        // R10 claim, then refused join of a claimed core (R6), then release
        alloc(8'h04, 8'h00, "R10");
        issue(0, 2, 0, "R6", 0);
        alloc(8'h00, 8'h24, "R10");
        // R7: width mismatch and non-joined group
        issue(1, 4, 0, "R7", 0);
        issue(1, 0, 1, "R7", 0);
        issue(1, 2, 0, "R7", 0);
        // R4 R5 R9: split quad at 4 with stray ack from core 0
        stray = 8'h01;
        issue(1, 4, 1, "R4", 0);
        stray = '0;
        issue(1, 0, 0, "R5", 0);
        // R3 R5: quad join at 0 then split
        issue(0, 0, 1, "R3", 0);
        issue(1, 0, 1, "R5", 0);
        issue(0, 6, 0, "R2", 0);

        $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
        $finish;
    end

endmodule